// File: doc/BRIEF.md
# Low-Frequency Tag Write Modulator

This block keys the carrier of a low-frequency reader on and off to write a 64-bit identifier and a 16-bit checksum into a passive transponder. A one-cycle start request captures the identifier and checksum from parallel inputs. The block then holds the carrier on for a charge interval, sends a fixed 112-bit frame as pulse-width-coded bit cells, and holds the carrier on for a programming interval. Finally it signals completion and turns the carrier off.

Each bit occupies a cell of fixed length. The carrier is off for the first part of the cell and on for the rest. The length of the off gap carries the bit value. All durations are whole microseconds, counted with a tick that a prescaler derives from the system clock. The prescaler restarts with every frame, so each microsecond is exactly `CLK_PER_US` clock cycles. A charge interval of N microseconds therefore lasts exactly N times `CLK_PER_US` cycles, counted from the first cycle after the accepting edge.

Top module: `lfw_writer`

## Requirements
- R1: While reset is asserted, and after reset until a start is accepted, `field_on`, `busy` and `done` are low.
- R2: A `start` sampled high while `busy` is low is accepted. From the next cycle `busy` is high and `field_on` is high for `CHARGE_US*CLK_PER_US` cycles.
- R3: A bit of value 1 is sent as `ONE_GAP_US*CLK_PER_US` cycles with `field_on` low, followed by `(CELL_US-ONE_GAP_US)*CLK_PER_US` cycles with it high.
- R4: A bit of value 0 is sent as `ZERO_GAP_US*CLK_PER_US` cycles with `field_on` low, followed by `(CELL_US-ZERO_GAP_US)*CLK_PER_US` cycles with it high.
- R5: The frame is 14 bytes, sent in this order: 0xBB, 0xEB, the identifier bytes from `tag_data[7:0]` up to `tag_data[63:56]`, `tag_sum[7:0]`, `tag_sum[15:8]`, 0x00 and 0x03.
- R6: Within each byte, bit 0 is sent first and bit 7 last.
- R7: After the high part of the last cell, `field_on` stays high for a further `PROG_US*CLK_PER_US` cycles. In the next cycle `done` is high for exactly one cycle, while `busy` and `field_on` are low.
- R8: While `busy` is high, `start` is ignored. Changes on `tag_data` and `tag_sum` have no effect on the frame in progress, because both are captured when the start is accepted.
- R9: A `start` presented in the cycle in which `done` is high is accepted. The next frame then begins with no idle cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to write one frame; honoured only while idle |
| tag_data | input | 64 | Identifier to write, captured on an accepted start |
| tag_sum | input | 16 | Checksum to write, captured on an accepted start |
| field_on | output | 1 | High turns the carrier on; low turns it off |
| busy | output | 1 | High from the accepted start through the programming interval |
| done | output | 1 | One-cycle pulse when the frame has finished |

## Verification
Two events can fall in the same cycle: completion of one frame and acceptance of the next. The `done` cycle is already idle, so a `start` held high in that cycle must launch a new charge interval immediately. The bench raises `start` on the exact cycle in which it first sees `done`. It then measures the second frame from the very next cycle and requires a full-length charge interval followed by the complete new frame. It also asserts `start` in the final stretch of an ordinary frame and changes `tag_data` and `tag_sum` at the same moment. In that case it expects the original waveform to continue unchanged and no second frame to follow.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

  localparam int ID_W        = 64;
  localparam int SUM_W       = 16;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 2 + ID_W / BYTE_W + SUM_W / BYTE_W + 2;
  localparam int FRAME_BITS  = FRAME_BYTES * BYTE_W;
  localparam int IDX_W       = $clog2(FRAME_BITS);

  localparam logic [7:0] HDR_KEY  = 8'hBB;
  localparam logic [7:0] HDR_PASS = 8'hEB;
  localparam logic [7:0] TRL_LO   = 8'h00;
  localparam logic [7:0] TRL_HI   = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHARGE,
    ST_GAP,
    ST_HOLD,
    ST_PROG
  } wr_state_e;

  // Frame image: bit 0 of the vector leaves the antenna first.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic [ID_W-1:0]  id,
    input logic [SUM_W-1:0] sum
  );
    return {TRL_HI, TRL_LO, sum, id, HDR_PASS, HDR_KEY};
  endfunction

  // Length of the carrier-off gap for one bit, in microseconds.
  function automatic int gap_us(input logic b, input int one_us, input int zero_us);
    return b ? one_us : zero_us;
  endfunction

endpackage

// File: rtl/lfw_tick.sv
module lfw_tick #(
  parameter int DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pc <= '0;
        else if (!run)                     pc <= '0;
        else if (pc == PW'(DIV - 1))       pc <= '0;
        else                               pc <= pc + 1'b1;
      end
      assign tick = run && (pc == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/lfw_timer.sv
module lfw_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == '0);
endmodule

// File: rtl/lfw_frame.sv
module lfw_frame
  import lfw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [ID_W-1:0]       id,
  input  logic [SUM_W-1:0]      sum,
  input  logic [IDX_W-1:0]      look_idx,
  output logic                  look_bit,
  output logic [FRAME_BITS-1:0] frame_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_q <= '0;
    else if (capture) frame_q <= build_frame(id, sum);
  end

  assign look_bit = frame_q[look_idx];
endmodule

// File: rtl/lfw_writer.sv
module lfw_writer
  import lfw_pkg::*;
#(
  parameter int CLK_PER_US  = 48,
  parameter int CHARGE_US   = 50000,
  parameter int ONE_GAP_US  = 1000,
  parameter int ZERO_GAP_US = 300,
  parameter int CELL_US     = 2000,
  parameter int PROG_US     = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] tag_data,
  input  logic [15:0] tag_sum,
  output logic        field_on,
  output logic        busy,
  output logic        done
);
  localparam int MAX_A = (CHARGE_US > PROG_US) ? CHARGE_US : PROG_US;
  localparam int MAX_D = (MAX_A > CELL_US) ? MAX_A : CELL_US;
  localparam int TW    = $clog2(MAX_D + 1);

  function automatic logic [TW-1:0] dur(input int us);
    return TW'(us - 1);
  endfunction

  wr_state_e               state_q, state_d;
  logic [IDX_W-1:0]        bit_idx, idx_d, look_idx;
  logic                    tick, expire, load, capture, cur_bit, last_bit;
  logic [TW-1:0]           load_val;
  logic [FRAME_BITS-1:0]   frame_q;
  int                      cur_gap;

  assign busy     = (state_q != ST_IDLE);
  assign field_on = (state_q == ST_CHARGE) || (state_q == ST_HOLD) || (state_q == ST_PROG);
  assign last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));
  // In the high part of a cell the next bit is looked up ahead of time.
  assign look_idx = (state_q == ST_HOLD && !last_bit) ? IDX_W'(bit_idx + 1'b1) : bit_idx;
  assign cur_gap  = gap_us(cur_bit, ONE_GAP_US, ZERO_GAP_US);

  lfw_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk (clk), .rst_n (rst_n), .run (busy), .tick (tick)
  );

  lfw_timer #(.W(TW)) u_timer (
    .clk (clk), .rst_n (rst_n), .load (load), .load_val (load_val),
    .tick (tick), .expire (expire)
  );

  lfw_frame u_frame (
    .clk (clk), .rst_n (rst_n), .capture (capture), .id (tag_data),
    .sum (tag_sum), .look_idx (look_idx), .look_bit (cur_bit), .frame_q (frame_q)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = bit_idx;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_CHARGE;
        idx_d    = '0;
        capture  = 1'b1;
        load     = 1'b1;
        load_val = dur(CHARGE_US);
      end
      ST_CHARGE: if (expire) begin
        state_d  = ST_GAP;
        load     = 1'b1;
        load_val = dur(cur_gap);
      end
      ST_GAP: if (expire) begin
        state_d  = ST_HOLD;
        load     = 1'b1;
        load_val = dur(CELL_US - cur_gap);
      end
      ST_HOLD: if (expire) begin
        load = 1'b1;
        if (last_bit) begin
          state_d  = ST_PROG;
          load_val = dur(PROG_US);
        end else begin
          state_d  = ST_GAP;
          idx_d    = IDX_W'(bit_idx + 1'b1);
          load_val = dur(cur_gap);
        end
      end
      ST_PROG: if (expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_idx <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_idx <= idx_d;
      done    <= (state_q == ST_PROG) && expire;
    end
  end
endmodule

// File: rtl/lfw_writer_chk.sv
module lfw_writer_chk
  import lfw_pkg::*;
#(
  parameter int CLK_PER_US  = 48,
  parameter int ONE_GAP_US  = 1000,
  parameter int ZERO_GAP_US = 300
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic                  field_on,
  input logic                  tick,
  input logic [IDX_W-1:0]      bit_idx,
  input logic [FRAME_BITS-1:0] frame_q
);
  int low_cyc;
  int exp_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_cyc <= 0;
    else if (busy && !field_on)  low_cyc <= low_cyc + 1;
    else                         low_cyc <= 0;
  end

  assign exp_low = gap_us(frame_q[bit_idx], ONE_GAP_US, ZERO_GAP_US) * CLK_PER_US;

  p_idle_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !field_on);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && field_on));

  // R3: gaps only open on a microsecond boundary
  p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(field_on) && busy) |-> $past(tick));

  // R3 and R4: gap width matches the bit being sent
  p_gap_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $rose(field_on)) |-> (low_cyc == exp_low));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= IDX_W'(FRAME_BITS - 1));

  p_done_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !field_on && $past(busy)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_frame_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_q));
endmodule

bind lfw_writer lfw_writer_chk #(
  .CLK_PER_US  (CLK_PER_US),
  .ONE_GAP_US  (ONE_GAP_US),
  .ZERO_GAP_US (ZERO_GAP_US)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .field_on (field_on),
  .tick     (tick),
  .bit_idx  (bit_idx),
  .frame_q  (frame_q)
);

// File: tb/tb_lfw_writer.sv
`timescale 1ns/1ps
module tb_lfw_writer;
  localparam int K    = 2;
  localparam int CH   = 20;
  localparam int ONE  = 5;
  localparam int ZERO = 2;
  localparam int CELL = 8;
  localparam int PROG = 15;

  localparam logic [79:0] VEC [3] = '{
    80'h0123456789ABCDEF_5A3C,
    80'hFFFFFFFFFFFFFFFF_0000,
    80'h0000000000000000_FFFF
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] d_in = '0;
  logic [15:0] c_in = '0;
  logic        field_on, busy, done;
  int n_chk = 0, n_fail = 0, cyc = 0, poke_at = -1;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lfw_writer #(
    .CLK_PER_US (K), .CHARGE_US (CH), .ONE_GAP_US (ONE),
    .ZERO_GAP_US (ZERO), .CELL_US (CELL), .PROG_US (PROG)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start (start), .tag_data (d_in),
    .tag_sum (c_in), .field_on (field_on), .busy (busy), .done (done)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // R5: byte k of the frame, counted from the first byte on air
  function automatic logic [7:0] frame_byte(input int k, input logic [63:0] d, input logic [15:0] c);
    if (k == 0)  return 8'hBB;
    if (k == 1)  return 8'hEB;
    if (k == 10) return c[7:0];
    if (k == 11) return c[15:8];
    if (k == 12) return 8'h00;
    if (k == 13) return 8'h03;
    return d[8*(k-2) +: 8];
  endfunction

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (field_on === lvl && n < 100000) begin
      n++;
      cyc++;
      if (cyc == poke_at) begin
        start = 1'b1; d_in = ~d_in; c_in = ~c_in;   // R8 stimulus
      end else if (cyc == poke_at + 1) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic [63:0] d, input logic [15:0] c, input bit pulse,
                           input bit chain, input logic [63:0] nd, input logic [15:0] nc);
    int len, g, ex;
    logic [7:0] by;
    logic b;
    if (pulse) begin
      @(negedge clk);
      d_in = d; c_in = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2 busy after accepted start", int'(busy), 1);
    end else begin
      start = 1'b0;
      chk(busy === 1'b1, "R9 start in done cycle accepted", int'(busy), 1);
    end
    run_len(1'b1, len);
    chk(len == CH*K, "R2 charge length", len, CH*K);
    for (int i = 0; i < 112; i++) begin
      by = frame_byte(i / 8, d, c);
      b  = by[i % 8];                 // R6: bit 0 of each byte first
      g  = b ? ONE : ZERO;
      run_len(1'b0, len);
      chk(len == g*K, $sformatf("%s R5 R6 gap of bit %0d", b ? "R3" : "R4", i), len, g*K);
      ex = (i == 111) ? (CELL - g + PROG) * K : (CELL - g) * K;
      run_len(1'b1, len);
      chk(len == ex, $sformatf("%s high part of bit %0d", (i == 111) ? "R7" : "R3 R4", i), len, ex);
    end
    chk(done === 1'b1, "R7 done after programming interval", int'(done), 1);
    chk(busy === 1'b0, "R7 busy low with done", int'(busy), 0);
    if (chain) begin
      d_in = nd; c_in = nc; start = 1'b1;
      @(negedge clk);
    end else begin
      @(negedge clk);
      chk(done === 1'b0, "R7 done lasts one cycle", int'(done), 0);
      chk(busy === 1'b0 && field_on === 1'b0, "R8 no frame after ignored start",
          int'(busy), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(field_on === 1'b0, "R1 field_on in reset", int'(field_on), 0);
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done === 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(field_on === 1'b0 && busy === 1'b0, "R1 idle after reset", int'(field_on), 0);

    for (int v = 0; v < 3; v++)
      run_frame(VEC[v][79:16], VEC[v][15:0], 1'b1, 1'b0, '0, '0);

    // R8: start and new inputs deep inside a frame are ignored
    poke_at = cyc + 400;
    run_frame(64'hA5A5_0F0F_3C3C_9696, 16'h1234, 1'b1, 1'b0, '0, '0);
    poke_at = cyc + 1700;
    run_frame(64'h1111_2222_4444_8888, 16'hBEEF, 1'b1, 1'b0, '0, '0);
    poke_at = -1;

    // R9: back-to-back frames, start raised in the done cycle
    run_frame(64'hDEAD_BEEF_CAFE_F00D, 16'h8001, 1'b1, 1'b1,
              64'h0F1E_2D3C_4B5A_6978, 16'h7E81);
    run_frame(64'h0F1E_2D3C_4B5A_6978, 16'h7E81, 1'b0, 1'b0, '0, '0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule